// File: doc/BRIEF.md
# Gated-Oscillator High-Resolution PWM

This block produces a pulse train at a fixed rate whose high time comes from a phase accumulator rather than from a compare register. A period timer marks the start of every cycle. Each start sets a gate flip-flop and drives the output high. While the gate is set, the accumulator adds the active increment word on every clock. The accumulator's carry-out clears the gate, which drives the output low and freezes the accumulator until the next start. A larger increment reaches the carry sooner and so gives a shorter pulse. The step between adjacent pulse widths is one part in 2^ACC_W of a full phase turn, not one whole clock, which is much finer than a counter-compare PWM running from the same clock.

The accumulator keeps its remainder after each carry and is never cleared. Consecutive pulses therefore differ by at most one clock, and their average falls between two adjacent clock counts. A host writes the increment through a one-cycle write strobe. The value is held as pending and becomes active only at the next period start, so a pulse already running always finishes with one increment. A one-cycle start strobe is brought out with the output so that a measuring circuit can align to each period. A saturation flag shows that a pulse was still running when a new period began.

Top module: `nco_hrpwm`

## Requirements
- R1: A synchronous reset clears the accumulator, the gate, the saturation flag and both increment registers (pending and active) to zero. While reset is held, `pwm_o`, `start_o` and `sat_o` read 0.
- R2: `start_o` is high for exactly one clock every P clocks, where P = max(`period_i`, 1). The first strobe comes in the first clock after reset is released.
- R3: `pwm_o` is high in the clock that follows each start strobe.
- R4: The accumulator adds the active increment once per clock while the gate is set, and it holds its value while the gate is clear.
- R5: With active increment I > 0 and accumulator value a at the period start, the pulse lasts n = ceil((2^ACC_W − a)/I) clocks. After the pulse the accumulator holds a + n·I − 2^ACC_W.
- R6: A write to the increment sets the pending value. The pending value becomes active only at the next start strobe, so the period in which the write occurs runs with the old increment.
- R7: With an active increment of zero, the output stays high for the whole period.
- R8: At each start strobe, `sat_o` becomes 1 if the gate was still set and no carry occurred in that clock, and 0 otherwise. It holds that value until the next start strobe.
- R9: A carry-out while the gate is set, with no start strobe in the same clock, drives `pwm_o` low in the next clock. Each pulse is one unbroken run that ends at the carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| period_i | input | PER_W | Period length in clocks |
| inc_wr_i | input | 1 | Increment write strobe |
| inc_data_i | input | INC_W | Increment value to write |
| pwm_o | output | 1 | Pulse output |
| start_o | output | 1 | One-clock period start strobe |
| sat_o | output | 1 | Previous pulse still running at period start |

## Verification
The bench builds the block with ACC_W=20, INC_W=16 and PER_W=8. At these values the largest increment still needs 16 clocks to wrap the accumulator, so periods of 40 to 100 clocks contain every tested pulse completely. Each tested increment gives a pulse width that moves between two adjacent clock counts from one period to the next. The bench follows the remainder from period to period with a closed-form ceiling division and checks the width of every pulse exactly. It also runs a zero-increment stretch to drive the saturation flag, and a reset in the middle of a pulse.

// File: rtl/nco_hrpwm_pkg.sv
package nco_hrpwm_pkg;

  // Period counter step: wraps to zero at the end of a period of per clocks.
  function automatic logic [31:0] timer_next(logic [31:0] cnt, logic [31:0] per);
    logic [32:0] bumped;
    bumped = {1'b0, cnt} + 33'd1;
    return (bumped >= {1'b0, per}) ? 32'd0 : bumped[31:0];
  endfunction

  // Phase step: both operands below 2^w, carry lands at bit w of the result.
  function automatic logic [32:0] phase_add(logic [31:0] acc, logic [31:0] inc);
    return {1'b0, acc} + {1'b0, inc};
  endfunction

endpackage

// File: rtl/hrpwm_period_timer.sv
module hrpwm_period_timer
  import nco_hrpwm_pkg::*;
#(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);
  logic [PER_W-1:0] cnt_q;
  logic [31:0]      cnt_nxt;

  assign cnt_nxt = timer_next(32'(cnt_q), 32'(period_i));
  assign tick_o  = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt[PER_W-1:0];
  end
endmodule

// File: rtl/hrpwm_inc_reg.sv
module hrpwm_inc_reg #(
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [INC_W-1:0] data_i,
  input  logic             load_i,
  output logic [INC_W-1:0] inc_o
);
  logic [INC_W-1:0] pend_q;
  logic [INC_W-1:0] act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_i)   pend_q <= data_i;
      if (load_i) act_q  <= pend_q;
    end
  end

  assign inc_o = act_q;
endmodule

// File: rtl/hrpwm_gated_acc.sv
module hrpwm_gated_acc
  import nco_hrpwm_pkg::*;
#(
  parameter int ACC_W = 20,
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic [INC_W-1:0] inc_i,
  output logic             gate_o,
  output logic             ovf_o,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] inc_ext;
  logic             gate_q;
  logic [32:0]      step;
  logic             carry;

  generate
    if (INC_W == ACC_W) begin : g_same_width
      assign inc_ext = inc_i;
    end else begin : g_zero_ext
      assign inc_ext = {{(ACC_W-INC_W){1'b0}}, inc_i};
    end
  endgenerate

  assign step  = phase_add(32'(acc_q), 32'(inc_ext));
  assign carry = step[ACC_W];
  assign ovf_o = gate_q & carry;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      if (gate_q) acc_q <= step[ACC_W-1:0];
      if (set_i)      gate_q <= 1'b1;
      else if (ovf_o) gate_q <= 1'b0;
    end
  end

  assign gate_o = gate_q;
  assign acc_o  = acc_q;
endmodule

// File: rtl/nco_hrpwm.sv
module nco_hrpwm
  import nco_hrpwm_pkg::*;
#(
  parameter int ACC_W = 20,
  parameter int INC_W = 16,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period_i,
  input  logic             inc_wr_i,
  input  logic [INC_W-1:0] inc_data_i,
  output logic             pwm_o,
  output logic             start_o,
  output logic             sat_o
);
  logic             tick;
  logic             gate;
  logic             ovf;
  logic [INC_W-1:0] inc_act;
  logic [ACC_W-1:0] acc;
  logic             sat_q;

  hrpwm_period_timer #(.PER_W(PER_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .period_i (period_i),
    .tick_o   (tick)
  );

  hrpwm_inc_reg #(.INC_W(INC_W)) u_inc (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (inc_wr_i),
    .data_i (inc_data_i),
    .load_i (tick),
    .inc_o  (inc_act)
  );

  hrpwm_gated_acc #(.ACC_W(ACC_W), .INC_W(INC_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .set_i  (tick),
    .inc_i  (inc_act),
    .gate_o (gate),
    .ovf_o  (ovf),
    .acc_o  (acc)
  );

  // Saturation: pulse still running when the next period begins.
  always_ff @(posedge clk) begin
    if (rst)       sat_q <= 1'b0;
    else if (tick) sat_q <= gate & ~ovf;
  end

  assign pwm_o   = gate;
  assign start_o = tick & ~rst;
  assign sat_o   = sat_q;
endmodule

// File: rtl/nco_hrpwm_chk.sv
module nco_hrpwm_chk #(
  parameter int ACC_W = 20,
  parameter int INC_W = 16,
  parameter int PER_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [PER_W-1:0] period_i,
  input logic             tick,
  input logic             gate,
  input logic             ovf,
  input logic [INC_W-1:0] inc_act,
  input logic [ACC_W-1:0] acc,
  input logic             pwm_o,
  input logic             sat_o
);
  AST_START_SPACED: assert property (@(posedge clk) disable iff (rst)
    (tick && period_i > 1) |=> !tick); // R2
  AST_RISE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    tick |=> pwm_o); // R3
  AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !gate |=> $stable(acc)); // R4
  AST_INC_HELD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(inc_act)); // R6
  AST_SAT_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(sat_o) |-> $past(tick)); // R8
  AST_FALL_ON_CARRY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !tick) |=> !pwm_o); // R9
endmodule

bind nco_hrpwm nco_hrpwm_chk #(.ACC_W(ACC_W), .INC_W(INC_W), .PER_W(PER_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .period_i (period_i),
  .tick     (tick),
  .gate     (gate),
  .ovf      (ovf),
  .inc_act  (inc_act),
  .acc      (acc),
  .pwm_o    (pwm_o),
  .sat_o    (sat_o)
);

// File: tb/nco_hrpwm_test.sv
`timescale 1ns/1ps
module nco_hrpwm_test;
  localparam int ACC_W = 20;
  localparam int INC_W = 16;
  localparam int PER_W = 8;
  localparam int NV    = 6;
  localparam int VINC [NV] = '{40000, 20000, 12345, 65535, 30000, 17000};
  localparam int VPER [NV] = '{64, 64, 100, 40, 50, 80};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [PER_W-1:0] period_i = PER_W'(64);
  logic             inc_wr_i = 1'b0;
  logic [INC_W-1:0] inc_data_i = '0;
  logic             pwm_o, start_o, sat_o;

  nco_hrpwm #(.ACC_W(ACC_W), .INC_W(INC_W), .PER_W(PER_W)) uut (
    .clk(clk), .rst(rst), .period_i(period_i), .inc_wr_i(inc_wr_i),
    .inc_data_i(inc_data_i), .pwm_o(pwm_o), .start_o(start_o), .sat_o(sat_o)
  );

  always #2.5 clk = ~clk;

  int     errs = 0;
  int     checks = 0;
  bit     done = 0;
  longint m_a;
  int     m_pend, m_act;
  bit     m_first;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_a = 0; m_pend = 0; m_act = 0; m_first = 1;
  endtask

  task automatic release_rst();
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R2 strobe in first clock after reset", start_o, 1);
  endtask

  // Entered in a start clock; returns in the next start clock.
  task automatic run_period(bit do_wr, int wdata, int per);
    int     len, high, last, satv, rise;
    longint n, full;
    bit     sat_exp;
    full = longint'(1) << ACC_W;
    period_i = PER_W'(per);
    len = 1; high = 0; last = 0; satv = 0; rise = 0;
    sat_exp = !m_first && (m_act == 0);
    m_act = m_pend;
    m_first = 0;
    while (1) begin
      @(negedge clk);
      if (inc_wr_i) inc_wr_i = 1'b0;
      if (start_o || len > 1000) break;
      if (len == 1) begin
        satv = sat_o;
        rise = pwm_o;
        if (do_wr) begin
          inc_wr_i = 1'b1;
          inc_data_i = INC_W'(wdata);
        end
      end
      if (pwm_o) begin
        high++;
        last = len;
      end
      len++;
    end
    if (m_act == 0) n = per - 1;
    else begin
      n = (full - m_a + m_act - 1) / m_act;
      m_a = m_a + n * m_act - full;
    end
    check("R2 period length", len, per);
    check("R3 high after start", rise, 1);
    if (m_act == 0) check("R7 zero increment holds high", high, n);
    else            check("R4 R5 R6 pulse width", high, n);
    check("R9 pulse ends at carry", last, n);
    check("R8 saturation flag", satv, sat_exp);
    if (do_wr) m_pend = wdata;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pwm low in reset", pwm_o, 0);
    check("R1 start low in reset", start_o, 0);
    check("R1 sat low in reset", sat_o, 0);
    model_reset();
    release_rst();
    run_period(1, VINC[0], VPER[0]);
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < 4; k++) begin
        run_period(k == 3 && v < NV - 1, (v < NV - 1) ? VINC[v + 1] : 0, VPER[v]);
      end
    end
    // Zero increment stretch, then recovery (R7, R8)
    run_period(1, 0, 64);
    for (int k = 0; k < 3; k++) run_period(0, 0, 64);
    run_period(1, 25000, 64);
    for (int k = 0; k < 3; k++) run_period(0, 0, 64);
    // Reset in the middle of a pulse (R1)
    repeat (5) @(negedge clk);
    check("R3 pulse running before reset", pwm_o, 1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 pwm cleared by reset", pwm_o, 0);
    check("R1 sat cleared by reset", sat_o, 0);
    check("R1 start held low by reset", start_o, 0);
    @(negedge clk);
    model_reset();
    release_rst();
    run_period(1, 40000, 64);
    run_period(0, 0, 64);
    run_period(0, 0, 64);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule